// File: doc/BRIEF.md
# Bit-Masked GPIO Register Bank

This block controls 32 general-purpose pins through a small word-addressed register interface. The pins are split into a low group (pins 0 to 15) and a high group (pins 16 to 31). Each group has its own direction register and its own output-level register. Each pin has an output-enable line that follows its direction bit and a drive line that follows its stored output bit. The pad can use these to build a tri-state buffer.

Every write to a direction or output register carries its own per-pin write enable. Bits 31:16 of the write word select which of the group's 16 pins are updated. Bits 15:0 carry the new values. Software can therefore flip one pin, or any subset of pins, in a single bus write without first reading the register back. Pin levels are read from a separate input register, which passes each pin through a two-flop synchroniser. Reads are registered: the data appears in the cycle after the read strobe.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset, all direction and output bits are 0, so `pin_oe` and `pin_out` are all zero and every register reads back as 0.
- R2: A write to an output register (offset 0x00 for pins 15:0, 0x04 for pins 31:16) updates only those pins of that group whose bit in `wdata[31:16]` is 1. Each such pin takes the value of the matching bit in `wdata[15:0]`. A write with a zero mask changes nothing.
- R3: A write to a direction register (offset 0x08 for pins 15:0, 0x0C for pins 31:16) applies the same per-pin mask rule to the direction bits.
- R4: A write to one group's register never changes the other group's pins, and a write to an output register never changes a direction bit, or the other way round.
- R5: `pin_oe[i]` is 1 exactly when pin i's direction bit is 1, and `pin_out[i]` equals pin i's stored output bit. Both take the new value in the cycle after the write edge.
- R6: A read of a direction or output register returns its 16 stored bits in `rdata[15:0]` with `rdata[31:16]` zero. `rdata` is loaded at the clock edge where `rd_en` is 1.
- R7: A read of offset 0x10 returns all 32 pin levels after a two-flop synchroniser. A pin change made just before edge k becomes visible to a read captured at edge k+2 or later, and is not visible to a read captured at edge k+1.
- R8: Writes to offset 0x10, to any other offset, or to a non-word-aligned offset change no register. Reads of an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write word: mask in 31:16, values in 15:0 |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pin levels from the pads |
| pin_out | output | 32 | Level driven on each pin |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
A corrupted stored bit shows up directly on `pin_out` or `pin_oe` one cycle after the write that caused it, so the bench checks both pin vectors after every write. A mask or bank-decode fault usually touches pins that the write should have left alone. The bench therefore keeps writing patterns whose masks exclude pins that already hold known values. A fault in the synchroniser chain or in the read mux only shows through `rdata`. It appears at the read that follows the pin change, and a read placed exactly one edge after the change exposes a chain that is too short.

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe
);
  localparam int HALF  = DATA_W / 2;
  localparam int NBANK = 2;
  localparam logic [ADDR_W-1:0] IN_A = ADDR_W'(4 * 2 * NBANK);

  logic [HALF-1:0]   out_q [NBANK];
  logic [HALF-1:0]   dir_q [NBANK];
  logic [NBANK-1:0]  hit_out, hit_dir;
  logic [DATA_W-1:0] sync1, sync2, rd_d;
  logic [HALF-1:0]   wmask, wval;

  assign wmask = wdata[DATA_W-1:HALF];
  assign wval  = wdata[HALF-1:0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] OUT_A = ADDR_W'(4 * b);
    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(4 * (NBANK + b));

    assign hit_out[b] = wr_en && (addr == OUT_A);
    assign hit_dir[b] = wr_en && (addr == DIR_A);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[b] <= '0;
        dir_q[b] <= '0;
      end else begin
        if (hit_out[b]) out_q[b] <= (out_q[b] & ~wmask) | (wval & wmask);
        if (hit_dir[b]) dir_q[b] <= (dir_q[b] & ~wmask) | (wval & wmask);
      end
    end

    assign pin_out[b*HALF +: HALF] = out_q[b];
    assign pin_oe[b*HALF +: HALF]  = dir_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_comb begin
    rd_d = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (addr == ADDR_W'(4 * b))           rd_d[HALF-1:0] = out_q[b];
      if (addr == ADDR_W'(4 * (NBANK + b))) rd_d[HALF-1:0] = dir_q[b];
    end
    if (addr == IN_A) rd_d = sync2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_d;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));

  assert_out_lo_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0)) |=>
      (((pin_out[HALF-1:0] ^ $past(pin_out[HALF-1:0])) & ~$past(wdata[DATA_W-1:HALF])) == '0));

  assert_dir_hi_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(12)) |=>
      (((pin_oe[DATA_W-1:HALF] ^ $past(pin_oe[DATA_W-1:HALF])) & ~$past(wdata[DATA_W-1:HALF])) == '0));

  assert_out_write_keeps_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == ADDR_W'(0) || addr == ADDR_W'(4))) |=> $stable(pin_oe));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr < IN_A) |=> (rdata[DATA_W-1:HALF] == '0));

  assert_input_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == IN_A) |=> (rdata == $past(sync2)));

  assert_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_out == '0 && hit_dir == '0) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/gpio_mask_bank_tb.sv
module gpio_mask_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe;

  int vectors = 0, miscompares = 0;
  logic [31:0] m_out = '0, m_dir = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mask_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    logic [15:0] m = d[31:16], v = d[15:0];
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      5'h00: m_out[15:0]  = (m_out[15:0]  & ~m) | (v & m);
      5'h04: m_out[31:16] = (m_out[31:16] & ~m) | (v & m);
      5'h08: m_dir[15:0]  = (m_dir[15:0]  & ~m) | (v & m);
      5'h0C: m_dir[31:16] = (m_dir[31:16] & ~m) | (v & m);
      default: ;
    endcase
  endtask

  task automatic pins(string tag);
    check({tag, " pin_out"}, pin_out, m_out);
    check({tag, " pin_oe"},  pin_oe,  m_dir);
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_en = 1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rd_all(string tag);
    rd(5'h00, {16'h0, m_out[15:0]},  {tag, " out_lo"});
    rd(5'h04, {16'h0, m_out[31:16]}, {tag, " out_hi"});
    rd(5'h08, {16'h0, m_dir[15:0]},  {tag, " dir_lo"});
    rd(5'h0C, {16'h0, m_dir[31:16]}, {tag, " dir_hi"});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("R6 unexpected read", rdata, 32'h0);
        else check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    pins("R1 reset");
    rd_all("R1 reset");

    wr(5'h00, 32'hFFFF_A5A5); pins("R2 full write lo");
    wr(5'h00, 32'h00F0_0000); pins("R2 clear bits 7:4");
    wr(5'h00, 32'h0000_FFFF); pins("R2 zero mask");
    wr(5'h04, 32'h8001_FFFF); pins("R4 hi bank only");
    wr(5'h08, 32'h0F0F_FFFF); pins("R3 dir lo masked");
    wr(5'h0C, 32'hFFFF_1234); pins("R5 dir hi full");
    wr(5'h0C, 32'h0030_0010); pins("R3 dir hi partial");
    wr(5'h04, 32'h0100_0100); pins("R4 out write leaves dir");
    rd_all("R6 readback");

    pin_in = 32'hDEAD_BEEF;
    rd(5'h10, 32'h0000_0000, "R7 one edge after change");
    @(negedge clk);
    rd(5'h10, 32'hDEAD_BEEF, "R7 settled input");
    @(negedge clk);
    pin_in = 32'h1234_5678;
    @(posedge clk); @(posedge clk);
    rd(5'h10, 32'h1234_5678, "R7 second pattern");

    wr(5'h10, 32'hFFFF_FFFF); pins("R8 write to input reg");
    wr(5'h14, 32'hFFFF_0000); pins("R8 write unmapped");
    wr(5'h02, 32'hFFFF_FFFF); pins("R8 write unaligned");
    rd(5'h14, 32'h0, "R8 read unmapped");
    rd(5'h01, 32'h0, "R8 read unaligned");
    rd_all("R8 regs intact");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R6 pending reads", 32'(exp_q.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule